// File: doc/BRIEF.md
# Embedded-Clock 10-bit Serializer

This block turns a 10-bit parallel word (one data byte plus two control bits) into a single serial bit stream. Each word is wrapped in a 12-bit symbol: a leading '1', the ten payload bits least significant first, and a trailing '0'. The fixed '0'-to-'1' step between one symbol's last bit and the next symbol's first bit happens in every symbol period whatever the payload. A receiver can recover the word clock from that step.

The block runs entirely on a bit clock at twelve times the word rate. The word-rate reference clock arrives as a signal and is sampled in the bit-clock domain. On the selected reference edge a parallel word is captured, and it moves into the shifter only at a symbol boundary. A synchronization request replaces data symbols with a six-ones, six-zeros training symbol. A powerdown input parks the framing logic. An output-enable input releases the line. The line is presented as a data bit and a drive-enable bit, and a pad driver outside this block turns the enable into a high-impedance state.

Top module: `emb_clk_serializer`

## Requirements
- R1: A data symbol is sent as 12 bit-clock periods: position 0 is '1', positions 1 to 10 carry par_data bits 0 to 9 in that order, and position 11 is '0'.
- R2: Every symbol period contains at least one level change on ser_dat, including for par_data all-zeros and all-ones and across consecutive symbols.
- R3: With cap_rise = 1 the word is captured when ref_clk goes from 0 to 1. With cap_rise = 0 it is captured when ref_clk goes from 1 to 0. Both cases are judged on ref_clk as sampled by bit_clk.
- R4: A symbol carries the most recently captured word as of its first bit. Changes of par_data at any other time do not alter a symbol already in progress.
- R5: sync_req is sampled only at a symbol boundary. When it is sampled high, the symbol is six '1' bits followed by six '0' bits, and this repeats for as long as it is high at each boundary.
- R6: pwr_down is registered on bit_clk. From the next edge on, ser_oe and ser_dat are 0 and the bit counter stays at the first position.
- R7: After pwr_down is released, the first bit period following the registering edge carries position 0 of a fresh symbol.
- R8: out_en = 0 forces ser_oe and ser_dat to 0 in the same cycle. It does not pause the symbol sequence.
- R9: During and after reset the block is powered down (ser_oe = 0), and the captured word is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, twelve times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Word-rate reference clock, sampled by bit_clk |
| cap_rise | input | 1 | 1: capture on reference rising edge, 0: on falling edge |
| par_data | input | 10 | Parallel word: bits 7..0 data byte, bits 9..8 control |
| sync_req | input | 1 | Send training symbols instead of data |
| pwr_down | input | 1 | Park the framing logic and release the line |
| out_en | input | 1 | 0 releases the line (high impedance at the pad) |
| ser_dat | output | 1 | Serial line data, 0 while not driven |
| ser_oe | output | 1 | Pad drive enable for ser_dat |

## Verification
The stimulus changes par_data on almost every bit period, so a design that loads the shifter from the live input rather than from the captured word corrupts the payload bits mid-symbol. sync_req is randomized every cycle, which exposes a design that switches pattern off a symbol boundary. The bench powers down in the middle of a symbol and changes the capture edge while parked. A design that resumes from the old bit position or keeps capturing on the old edge then sends shifted or stale symbols. Held all-zero and all-ones words confirm that the start and stop bits still give each symbol its transition.

// File: rtl/emb_ser_pkg.sv
package emb_ser_pkg;

    typedef enum logic {
        MODE_DATA = 1'b0,
        MODE_SYNC = 1'b1
    } frame_mode_e;

    localparam logic START_LVL = 1'b1;
    localparam logic STOP_LVL  = 1'b0;

endpackage

// File: rtl/ems_capture.sv
module ems_capture #(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              cap_rise,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic              ref_q;
        logic [WORD_W-1:0] word;
    } cap_s;

    cap_s q, d;
    logic edge_hit;

    always_comb begin
        d = q;
        d.ref_q = ref_clk;
        if (cap_rise) begin
            edge_hit = ref_clk & ~q.ref_q;
        end else begin
            edge_hit = ~ref_clk & q.ref_q;
        end
        if (edge_hit) begin
            d.word = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word = q.word;

    // R3: a selected edge loads the word seen in that cycle
    a_r3_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (word == $past(din)));

    // R4: with no selected edge the captured word stays put
    a_r4_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_clk == q.ref_q) |=> $stable(word));

endmodule

// File: rtl/ems_shifter.sv
module ems_shifter
    import emb_ser_pkg::*;
#(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_off,
    input  logic              sync_req,
    input  logic [WORD_W-1:0] word,
    output logic              ser_bit,
    output logic              at_start
);

    localparam int unsigned FRAME_W   = WORD_W + 2;
    localparam int unsigned SYNC_ONES = FRAME_W / 2;
    localparam int unsigned CNT_W     = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] SYNC_POS = CNT_W'(SYNC_ONES);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        frame_mode_e        mode;
    } shf_s;

    shf_s q, d;
    logic [FRAME_W-1:0] sync_sym;
    logic [FRAME_W-1:0] data_sym;
    logic [FRAME_W-1:0] next_sym;

    always_comb begin
        for (int unsigned i = 0; i < FRAME_W; i++) begin
            sync_sym[i] = (i < SYNC_ONES);
        end
        data_sym = {STOP_LVL, word, START_LVL};
        next_sym = sync_req ? sync_sym : data_sym;

        d = q;
        if (hold_off || (q.cnt == LAST_POS)) begin
            d.cnt  = '0;
            d.sh   = next_sym;
            d.mode = sync_req ? MODE_SYNC : MODE_DATA;
        end else begin
            d.cnt = q.cnt + 1'b1;
            d.sh  = {1'b0, q.sh[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.sh   <= {STOP_LVL, {WORD_W{1'b0}}, START_LVL};
            q.mode <= MODE_DATA;
        end else begin
            q <= d;
        end
    end

    assign ser_bit  = q.sh[0];
    assign at_start = (q.cnt == '0);

    // R1: first bit of every data symbol is the start level
    a_r1_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_off && at_start && q.mode == MODE_DATA) |-> (ser_bit == START_LVL));

    // R2: last bit of every symbol is low, so the next start bit is a rise
    a_r2_stop_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_off && q.cnt == LAST_POS) |-> (ser_bit == 1'b0));

    // R5: training symbol is ones in the first half, zeros in the second
    a_r5_sync_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_SYNC) |-> (ser_bit == (q.cnt < SYNC_POS)));

    // R4: inside a symbol the shifter only moves, it never reloads
    a_r4_no_midframe_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_off && q.cnt != LAST_POS)
        |=> (q.sh[FRAME_W-2:0] == $past(q.sh[FRAME_W-1:1])) && $stable(q.mode));

    // R6: while parked the counter stays at the first position
    a_r6_parked_count: assert property (@(posedge clk) disable iff (!rst_n)
        hold_off |=> at_start);

endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer #(
    parameter int unsigned WORD_W = 10
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic              cap_rise,
    input  logic [WORD_W-1:0] par_data,
    input  logic              sync_req,
    input  logic              pwr_down,
    input  logic              out_en,
    output logic              ser_dat,
    output logic              ser_oe
);

    typedef struct packed {
        logic pd;
    } top_s;

    top_s q, d;
    logic [WORD_W-1:0] cap_word;
    logic              shf_bit;
    logic              shf_start;

    always_comb begin
        d    = q;
        d.pd = pwr_down;
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    ems_capture #(.WORD_W(WORD_W)) u_capture (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .cap_rise (cap_rise),
        .din      (par_data),
        .word     (cap_word)
    );

    ems_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .hold_off (q.pd),
        .sync_req (sync_req),
        .word     (cap_word),
        .ser_bit  (shf_bit),
        .at_start (shf_start)
    );

    assign ser_oe  = out_en & ~q.pd;
    assign ser_dat = ser_oe & shf_bit;

    // R7: leaving powerdown always lands on the first symbol position
    a_r7_clean_restart: assert property (@(posedge bit_clk) disable iff (!rst_n)
        q.pd |=> (q.pd || shf_start));

    // R6: a registered powerdown request releases the line on the next edge
    a_r6_line_released: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pwr_down |=> !ser_oe);

endmodule

// File: tb/tb_emb_clk_serializer.sv
module tb_emb_clk_serializer;

    localparam int W = 10;
    localparam int F = 12;

    logic         bit_clk = 1'b0;
    logic         rst_n;
    logic         ref_clk;
    logic         cap_rise;
    logic [W-1:0] par_data;
    logic         sync_req;
    logic         pwr_down;
    logic         out_en;
    logic         ser_dat;
    logic         ser_oe;

    int vectors     = 0;
    int miscompares = 0;
    int idx         = 0;
    int since_rel   = 0;
    logic [W-1:0] cap_word  = '0;
    logic [W-1:0] next_word = '0;
    logic [W-1:0] fr_word   = '0;
    logic         next_sync = 1'b0;
    logic         fr_sync   = 1'b0;
    logic         pd_prev   = 1'b1;
    logic         oe_prev   = 1'b0;
    logic         first_run = 1'b1;

    always #10 bit_clk = ~bit_clk;

    emb_clk_serializer #(.WORD_W(W)) dut (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .cap_rise (cap_rise),
        .par_data (par_data),
        .sync_req (sync_req),
        .pwr_down (pwr_down),
        .out_en   (out_en),
        .ser_dat  (ser_dat),
        .ser_oe   (ser_oe)
    );

    function automatic logic exp_bit(input logic s, input logic [W-1:0] w, input int j);
        if (s) return (j < F / 2);
        if (j == 0) return 1'b1;
        if (j == F - 1) return 1'b0;
        return w[j-1];
    endfunction

    task automatic check(input logic exp_oe, input logic exp_dat, input string tag);
        vectors++;
        if (ser_oe !== exp_oe || ser_dat !== exp_dat) begin
            miscompares++;
            $display("FAIL %s: idx %0d got oe=%0b dat=%0b expected oe=%0b dat=%0b",
                     tag, idx, ser_oe, ser_dat, exp_oe, exp_dat);
        end
    endtask

    task automatic tick(input logic pd, input logic sync, input logic oe, input logic [W-1:0] dat);
        int    j;
        string tag;
        @(negedge bit_clk);
        j = (idx + F - 1) % F;
        if (idx % F == 1) begin
            fr_word = next_word;
            fr_sync = next_sync;
            if (!pd_prev) since_rel++;
        end
        if (pd_prev) begin
            check(1'b0, 1'b0, "R6");
        end else if (!oe_prev) begin
            check(1'b0, 1'b0, "R8");
        end else begin
            if (fr_sync)                    tag = "R5";
            else if (j == 0 && since_rel == 1) tag = "R7 R1";
            else if (j == 0 || j == F - 1)  tag = "R1 R2";
            else if (first_run && since_rel == 1) tag = "R9 R4";
            else if (!cap_rise)             tag = "R3 R4";
            else                            tag = "R1 R4";
            check(1'b1, exp_bit(fr_sync, fr_word, j), tag);
        end
        ref_clk  = ((idx % F) >= 3) && ((idx % F) < 9);
        pwr_down = pd;
        sync_req = sync;
        out_en   = oe;
        par_data = dat;
        if (idx % F == 3 && cap_rise)  cap_word = dat;
        if (idx % F == 9 && !cap_rise) cap_word = dat;
        if (idx % F == 0) begin
            next_word = cap_word;
            next_sync = sync;
        end
        if (pd) since_rel = 0;
        pd_prev = pd;
        oe_prev = oe;
        idx++;
    endtask

    task automatic run_random(input int frames, input int sync_pct);
        for (int k = 0; k < frames * F; k++) begin
            tick(1'b0, ($urandom % 100) < sync_pct, ($urandom % 8) != 0, W'($urandom));
        end
    endtask

    task automatic run_held(input int frames, input logic sync, input logic [W-1:0] dat);
        for (int k = 0; k < frames * F; k++) begin
            tick(1'b0, sync, 1'b1, dat);
        end
    endtask

    initial begin
        #(200000 * 20);
        miscompares++;
        $display("FAIL watchdog R1: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd5151));
        rst_n    = 1'b0;
        ref_clk  = 1'b0;
        cap_rise = 1'b1;
        par_data = '0;
        sync_req = 1'b0;
        pwr_down = 1'b1;
        out_en   = 1'b1;
        repeat (3) @(negedge bit_clk);
        check(1'b0, 1'b0, "R9");
        rst_n = 1'b1;

        // first frame after reset carries the all-zero captured word (R9)
        run_held(1, 1'b0, 10'h155);
        first_run = 1'b0;
        run_random(30, 20);

        // transition corners (R2): constant payloads and back-to-back symbols
        run_held(3, 1'b0, '0);
        run_held(3, 1'b0, '1);
        run_held(2, 1'b0, 10'h2AA);

        // sustained training symbols (R5)
        run_held(4, 1'b1, 10'h0F0);

        // powerdown entered mid-symbol, capture edge flipped while parked (R6, R3)
        while (idx % F != 5) tick(1'b0, 1'b0, 1'b1, W'($urandom));
        for (int k = 0; k < 30; k++) begin
            if (k == 4) cap_rise = 1'b0;
            tick(1'b1, 1'b0, 1'b1, W'($urandom));
        end
        while (idx % F != 0) tick(1'b1, 1'b0, 1'b1, W'($urandom));

        // restart and run with falling-edge capture (R7, R3, R4)
        run_random(30, 20);
        run_held(2, 1'b0, '1);

        // back to rising edge via another powerdown
        for (int k = 0; k < F * 2; k++) begin
            if (k == 3) cap_rise = 1'b1;
            tick(1'b1, 1'b1, 1'b1, W'($urandom));
        end
        run_random(20, 50);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule